// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block is the device side of a double-data-rate read path. It takes decoded commands: read with a start column and an auto-precharge flag, burst stop, and precharge. A configured number of cycles after a read (two or three), it returns a burst of data elements, two per clock. Each clock cycle shows two single-rate lanes: the rising-edge element and the falling-edge element. The data strobe travels with the data. It is driven low for one cycle before a burst that starts from an idle bus, and it is low together with the last element of every cycle. When no burst is running, the lanes are released through per-lane output-enable bits.

Bursts can be chained with no gap. A later read, a stop or a precharge command cuts the running burst short with the same delay as the read latency, so the number of element pairs delivered equals the spacing between the commands. A read issued with its auto-precharge flag set raises a one-cycle row-precharge indication after it completes naturally. The array contents are behavioural: the word stored at column `a` is `{~a, a}`.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: While `rstN` is low, every output is zero: both enables, both data lanes, `dqsOe`, `dqsRise`, `dqsFall` and `rowPrecharge`.
- R2: When a read is held on the inputs in cycle c, its first element pair appears in cycle c+CL. CL is 2 when `casSel`=0 and 3 when `casSel`=1.
- R3: In data pair j of a burst with start column s and length BL, the rising lane carries column (s & ~(BL-1)) | ((s+2j) & (BL-1)). The falling lane carries the next column, wrapped inside the same aligned block. The word for column a is `{~a, a}`.
- R4: `burstSel` selects BL: 00 gives 2, 01 gives 4, 10 gives 8. An uninterrupted burst drives `oeRise`/`oeFall` for exactly BL/2 cycles.
- R5: If no pair is being output in cycle c+CL-1, then in that cycle `dqsOe` is 1 and both strobe lanes are 0 (the preamble).
- R6: In every data cycle, including the last one, `dqsRise`=1 and `dqsFall`=0, so the strobe is low with the final element. `dqsOe` is 0 in any cycle that has neither data nor preamble.
- R7: A read in cycle r after a read in cycle c<r ends the earlier burst after cycle r+CL-1. The new burst begins in cycle r+CL with no idle cycle and no preamble. A read may be issued in every cycle.
- R8: A stop command in cycle t leaves t+CL-1 as the last possible data cycle; from cycle t+CL on, no data is driven.
- R9: A precharge command truncates data with the same timing as a stop command.
- R10: A burst whose read had the auto-precharge flag set, and which reaches its full length, pulses `rowPrecharge` for one cycle: the cycle after its last data pair. A truncated burst gives no pulse.
- R11: In a cycle without data, both lane enables are 0 and both data lanes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| casSel | input | 1 | Read latency select: 0 gives 2, 1 gives 3 |
| burstSel | input | 2 | Burst length select |
| cmdRead | input | 1 | Read command |
| cmdTerm | input | 1 | Burst stop command |
| cmdPre | input | 1 | Precharge command |
| cmdCol | input | COL_W | Start column of a read |
| cmdAutoPre | input | 1 | Auto-precharge flag of a read |
| dataRise | output | 2*COL_W | Rising-edge data element |
| dataFall | output | 2*COL_W | Falling-edge data element |
| oeRise | output | 1 | Rising-lane output enable |
| oeFall | output | 1 | Falling-lane output enable |
| dqsOe | output | 1 | Strobe output enable |
| dqsRise | output | 1 | Strobe level in the first half-cycle |
| dqsFall | output | 1 | Strobe level in the second half-cycle |
| rowPrecharge | output | 1 | One-cycle auto-precharge indication |

## Verification
The effects of a command held in cycle c are due at fixed cycles:
- the preamble in c+CL-1;
- the first pair, or the stop of data, in c+CL;
- the row-precharge pulse in the cycle after the last pair.

The reference model files each command into a slot keyed by the cycle in which its effect is due. On every rising edge it advances its burst state by that slot. The bench compares every output with the model at each falling edge, while the outputs are stable. Scenarios cover:
- both latencies and all three burst lengths;
- odd start columns that wrap;
- reads that chain back-to-back or cut a burst short;
- stop and precharge truncation;
- auto-precharge on a complete burst and on a truncated one.

// File: rtl/ddr_rd_seq_pkg.sv
package ddr_rd_seq_pkg;

  localparam int PAIR_W = 3;

  typedef struct packed {
    logic load;
    logic advance;
    logic active;
  } seqCtl_t;

  function automatic logic [PAIR_W-1:0] pairsFor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] elemMask(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd1;
      2'b01:   return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/ddr_rd_seq_ctrl.sv
module ddr_rd_seq_ctrl
  import ddr_rd_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             casSel,
  input  logic [1:0]       burstSel,
  input  logic             cmdRead,
  input  logic             cmdTerm,
  input  logic             cmdPre,
  input  logic [COL_W-1:0] cmdCol,
  input  logic             cmdAutoPre,
  output seqCtl_t          ctl,
  output logic [COL_W-1:0] tapCol,
  output logic             dqsOe,
  output logic             dqsRise,
  output logic             dqsFall,
  output logic             rowPrecharge
);

  localparam int CAS_MIN = 2;
  localparam int CAS_MAX = 3;
  localparam int PIPE_D  = CAS_MAX - 1;

  // command delay line: stage i is visible i+1 cycles after issue
  logic [PIPE_D-1:0] pRead, pStop, pAuto;
  logic [COL_W-1:0]  pCol [PIPE_D];

  logic              tapRead, tapStop, tapAuto;
  logic              active, autoFlag, preamble;
  logic [PAIR_W-1:0] pairsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pRead <= '0;
      pStop <= '0;
      pAuto <= '0;
      for (int i = 0; i < PIPE_D; i++) pCol[i] <= '0;
    end else begin
      pRead[0] <= cmdRead;
      pStop[0] <= cmdTerm | cmdPre;
      pAuto[0] <= cmdAutoPre;
      pCol[0]  <= cmdCol;
      for (int i = 1; i < PIPE_D; i++) begin
        pRead[i] <= pRead[i-1];
        pStop[i] <= pStop[i-1];
        pAuto[i] <= pAuto[i-1];
        pCol[i]  <= pCol[i-1];
      end
    end
  end

  // stage (CL - CAS_MIN) holds the command whose data starts next cycle
  assign tapRead = pRead[casSel];
  assign tapStop = pStop[casSel];
  assign tapAuto = pAuto[casSel];
  assign tapCol  = pCol[casSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active       <= 1'b0;
      pairsLeft    <= '0;
      autoFlag     <= 1'b0;
      rowPrecharge <= 1'b0;
    end else if (tapRead) begin
      active       <= 1'b1;
      pairsLeft    <= pairsFor(burstSel);
      autoFlag     <= tapAuto;
      rowPrecharge <= 1'b0;
    end else if (tapStop) begin
      active       <= 1'b0;
      autoFlag     <= 1'b0;
      rowPrecharge <= 1'b0;
    end else if (active) begin
      pairsLeft <= pairsLeft - 1'b1;
      if (pairsLeft == 1) begin
        active       <= 1'b0;
        rowPrecharge <= autoFlag;
      end else begin
        rowPrecharge <= 1'b0;
      end
    end else begin
      rowPrecharge <= 1'b0;
    end
  end

  assign preamble    = tapRead & ~active;
  assign ctl.load    = tapRead;
  assign ctl.advance = active & ~tapRead & ~tapStop;
  assign ctl.active  = active;

  assign dqsOe   = active | preamble;
  assign dqsRise = active;
  assign dqsFall = 1'b0;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdRead, cmdTerm, cmdPre})); // R7
  AST_CAS2_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && !casSel) |-> ##2 active); // R2
  AST_CAS3_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && casSel) |-> ##3 active); // R2
  AST_PREAMBLE_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    preamble |=> (active && dqsRise)); // R5
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    tapStop |=> !active); // R8
  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (active && pairsLeft == 1 && !tapRead && !tapStop) |=> !active); // R4
  AST_ROWPRE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rowPrecharge |=> !rowPrecharge); // R10

endmodule

// File: rtl/ddr_rd_seq_dp.sv
module ddr_rd_seq_dp
  import ddr_rd_seq_pkg::*;
#(
  parameter int COL_W = 8,
  localparam int DW   = 2 * COL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [COL_W-1:0] tapCol,
  input  logic [1:0]       burstSel,
  output logic [DW-1:0]    dataRise,
  output logic [DW-1:0]    dataFall,
  output logic             oeRise,
  output logic             oeFall
);

  logic [COL_W-1:0] startCol;
  logic [2:0]       offset;
  logic [COL_W-1:0] maskExt, sumRise, sumFall, colRise, colFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCol <= '0;
      offset   <= '0;
    end else if (ctl.load) begin
      startCol <= tapCol;
      offset   <= '0;
    end else if (ctl.advance) begin
      offset <= offset + 3'd2;
    end
  end

  assign maskExt = {{(COL_W-3){1'b0}}, elemMask(burstSel)};
  assign sumRise = startCol + {{(COL_W-3){1'b0}}, offset};
  assign sumFall = sumRise + 1'b1;
  assign colRise = (startCol & ~maskExt) | (sumRise & maskExt);
  assign colFall = (startCol & ~maskExt) | (sumFall & maskExt);

  // behavioural array: word at column a is {~a, a}
  assign dataRise = ctl.active ? {~colRise, colRise} : '0;
  assign dataFall = ctl.active ? {~colFall, colFall} : '0;
  assign oeRise   = ctl.active;
  assign oeFall   = ctl.active;

endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
  import ddr_rd_seq_pkg::*;
#(
  parameter int COL_W = 8,
  localparam int DW   = 2 * COL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             casSel,
  input  logic [1:0]       burstSel,
  input  logic             cmdRead,
  input  logic             cmdTerm,
  input  logic             cmdPre,
  input  logic [COL_W-1:0] cmdCol,
  input  logic             cmdAutoPre,
  output logic [DW-1:0]    dataRise,
  output logic [DW-1:0]    dataFall,
  output logic             oeRise,
  output logic             oeFall,
  output logic             dqsOe,
  output logic             dqsRise,
  output logic             dqsFall,
  output logic             rowPrecharge
);

  seqCtl_t          ctl;
  logic [COL_W-1:0] tapCol;

  ddr_rd_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .casSel(casSel), .burstSel(burstSel),
    .cmdRead(cmdRead), .cmdTerm(cmdTerm), .cmdPre(cmdPre),
    .cmdCol(cmdCol), .cmdAutoPre(cmdAutoPre),
    .ctl(ctl), .tapCol(tapCol),
    .dqsOe(dqsOe), .dqsRise(dqsRise), .dqsFall(dqsFall),
    .rowPrecharge(rowPrecharge)
  );

  ddr_rd_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tapCol(tapCol),
    .burstSel(burstSel),
    .dataRise(dataRise), .dataFall(dataFall),
    .oeRise(oeRise), .oeFall(oeFall)
  );

  AST_DATA_HAS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    oeRise |-> (dqsOe && dqsRise && !dqsFall)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !oeFall |-> (dataFall == '0)); // R11

endmodule

// File: tb/ddr_rd_burst_seq_bench.sv
`timescale 1ns/1ps
module ddr_rd_burst_seq_bench;

  localparam int COL_W = 8;
  localparam int DW    = 2 * COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             casSel = 1'b0;
  logic [1:0]       burstSel = 2'b00;
  logic             cmdRead = 1'b0, cmdTerm = 1'b0, cmdPre = 1'b0;
  logic [COL_W-1:0] cmdCol = '0;
  logic             cmdAutoPre = 1'b0;
  logic [DW-1:0]    dataRise, dataFall;
  logic             oeRise, oeFall, dqsOe, dqsRise, dqsFall, rowPrecharge;

  ddr_rd_burst_seq #(.COL_W(COL_W)) u_ddr_rd_burst_seq (
    .clk(clk), .rstN(rstN), .casSel(casSel), .burstSel(burstSel),
    .cmdRead(cmdRead), .cmdTerm(cmdTerm), .cmdPre(cmdPre),
    .cmdCol(cmdCol), .cmdAutoPre(cmdAutoPre),
    .dataRise(dataRise), .dataFall(dataFall),
    .oeRise(oeRise), .oeFall(oeFall), .dqsOe(dqsOe),
    .dqsRise(dqsRise), .dqsFall(dqsFall), .rowPrecharge(rowPrecharge)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string scen = "R1";
  int tbCL = 2, tbPairs = 1, tbMask = 1;

  // events keyed by the cycle in which their effect begins
  int evKind [16];  // 0 none, 1 read, 2 stop
  int evCol  [16];
  int evAuto [16];
  int evPairs[16];
  int evMask [16];

  // reference burst state for the current cycle
  bit mAct = 0, mAuto = 0, mPulse = 0;
  int mStart = 0, mK = 0, mLeft = 0, mMask = 0;

  initial for (int i = 0; i < 16; i++) evKind[i] = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mPulse = 0; mK = 0; mLeft = 0;
    end else begin
      int s;
      s = (cyc + 1) % 16;
      if (evKind[s] == 1) begin
        mAct = 1; mStart = evCol[s]; mK = 0; mLeft = evPairs[s];
        mMask = evMask[s]; mAuto = (evAuto[s] != 0); mPulse = 0;
      end else if (evKind[s] == 2) begin
        mAct = 0; mPulse = 0;
      end else if (mAct) begin
        mK++; mLeft--;
        if (mLeft == 0) begin mAct = 0; mPulse = mAuto; end
        else mPulse = 0;
      end else mPulse = 0;
      evKind[s] = 0;
    end
    cyc++;
  end

  task automatic chk(string what, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s (scenario %s) cycle %0d: got %h expected %h",
               tag, what, scen, cyc, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(int col);
    logic [COL_W-1:0] a;
    a = col[COL_W-1:0];
    return {~a, a};
  endfunction

  task automatic checkNow();
    int cr, cf;
    bit pre;
    string dt;
    pre = (evKind[(cyc + 1) % 16] == 1) && !mAct;
    cr = (mStart & ~mMask) | ((mStart + 2*mK) & mMask);
    cf = (mStart & ~mMask) | ((mStart + 2*mK + 1) & mMask);
    dt = mAct ? "R3" : "R11";
    chk("oeRise", "R2/R4", {31'b0, oeRise}, {31'b0, mAct});
    chk("oeFall", "R2/R4", {31'b0, oeFall}, {31'b0, mAct});
    chk("dataRise", dt, {16'b0, dataRise}, mAct ? {16'b0, word(cr)} : 32'b0);
    chk("dataFall", dt, {16'b0, dataFall}, mAct ? {16'b0, word(cf)} : 32'b0);
    chk("dqsOe", "R5/R6", {31'b0, dqsOe}, {31'b0, mAct | pre});
    chk("dqsRise", "R5/R6", {31'b0, dqsRise}, {31'b0, mAct});
    chk("dqsFall", "R6", {31'b0, dqsFall}, 32'b0);
    chk("rowPrecharge", "R10", {31'b0, rowPrecharge}, {31'b0, mPulse});
  endtask

  // one cycle: check outputs of this cycle, then present a command
  task automatic tick(bit rd = 0, bit tm = 0, bit pr = 0, int col = 0, bit ap = 0);
    int s;
    @(negedge clk);
    checkNow();
    cmdRead = rd; cmdTerm = tm; cmdPre = pr;
    cmdCol = col[COL_W-1:0]; cmdAutoPre = ap;
    s = (cyc + tbCL) % 16;
    if (rd) begin
      evKind[s] = 1; evCol[s] = col; evAuto[s] = ap;
      evPairs[s] = tbPairs; evMask[s] = tbMask;
    end else if (tm || pr) evKind[s] = 2;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setCfg(int cl, int bl);
    casSel = (cl == 3);
    burstSel = (bl == 2) ? 2'b00 : (bl == 4) ? 2'b01 : 2'b10;
    tbCL = cl; tbPairs = bl / 2; tbMask = bl - 1;
  endtask

  initial begin
    // R1: reset state, with a read held to show it is ignored in reset
    cmdRead = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("oe in reset", "R1", {30'b0, oeRise, oeFall}, 32'b0);
      chk("data in reset", "R1", {dataRise, dataFall}, 32'b0);
      chk("strobe in reset", "R1", {28'b0, dqsOe, dqsRise, dqsFall, rowPrecharge}, 32'b0);
    end
    cmdRead = 1'b0;
    rstN = 1'b1;
    idle(3);

    scen = "R2 cl2 bl4 odd wrap";
    setCfg(2, 4); tick(1, 0, 0, 8'h05); idle(6);

    scen = "R4 cl3 bl8 autopre R10";
    setCfg(3, 8); tick(1, 0, 0, 8'h13, 1); idle(9);

    scen = "R4 cl2 bl2";
    setCfg(2, 2); tick(1, 0, 0, 8'h2A); idle(5);

    scen = "R7 truncate by read";
    setCfg(2, 8); tick(1, 0, 0, 8'h00); tick(); tick(1, 0, 0, 8'h46); idle(8);

    scen = "R7 read every cycle";
    setCfg(3, 2);
    for (int i = 0; i < 5; i++) tick(1, 0, 0, 8'h80 + 2*i, i[0]);
    idle(6);

    scen = "R7 concatenate at end";
    setCfg(3, 4); tick(1, 0, 0, 8'h31); tick(); tick(1, 0, 0, 8'h6E, 1); idle(7);

    scen = "R8 stop";
    setCfg(2, 8); tick(1, 0, 0, 8'h17, 1); tick(); tick(0, 1); idle(8);

    scen = "R9 precharge";
    setCfg(3, 8); tick(1, 0, 0, 8'hC3, 1); tick(); tick(); tick(0, 0, 1); idle(9);

    scen = "R11 idle";
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (scenario %s): got hang expected completion", scen);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule